// File: doc/BRIEF.md
# Pushbutton Nibble Accumulator

This block keeps an 8-bit unsigned running total. Each press of an "add" pushbutton adds a 4-bit switch value to it. A "clear" pushbutton returns the total to zero. A "show high" pushbutton chooses which half of the total drives four LED lines.

A free-running cycle counter makes a one-cycle enable pulse every `TICK_DIV` clocks. At 12 MHz the default of 1,200,000 gives one pulse every 0.1 s. The buttons are looked at only on those enabled cycles, and this slow sampling is how the block debounces them. An add is taken only when the sampled add button reads 1 and its previous sample, stored in a register, read 0. A press held over many ticks therefore adds once.

The LED multiplexer is pure logic from the show-high level and the total, so the display follows that button at once and does not wait for a tick.

Top module: `nibble_accum`

## Requirements
- R1: On an accepted press, the total becomes the old total plus the 4-bit switch value `din`. Both are unsigned: the total is 8 bits and `din` is 4 bits.
- R2: The buttons act only on tick cycles, which come once every `TICK_DIV` clocks. The first tick is acted on at clock edge number `TICK_DIV` after power-up. An add pulse that rises and falls between two ticks has no effect.
- R3: One press adds exactly once, however many ticks the add button stays at 1.
- R4: A press is accepted only when the sampled add button is 1 and the previous sample is 0. The previous sample is reloaded on every tick.
- R5: The total wraps modulo 256. There is no saturation and no carry output. For example, 13 adds of 15 from zero give 195, and five more give 14.
- R6: `led` equals bits 7..4 of the total while `show_hi` is 1, and bits 3..0 while it is 0. It changes in the same cycle that `show_hi` changes.
- R7: After power-up, the total, the previous add sample and the tick counter are all zero, so `led` reads 0 for both halves.
- R8: When `btn_clr` is 1 on a tick, the total becomes 0, even if an add is accepted on that same tick.
- R9: The previous add sample keeps updating while `btn_clr` is held. An add button held through the release of clear therefore causes no addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (12 MHz nominal) |
| din | input | 4 | Unsigned addend from the switches |
| btn_clr | input | 1 | Clear pushbutton, active high |
| btn_add | input | 1 | Add pushbutton, active high |
| show_hi | input | 1 | Selects the high nibble for display, active high |
| led | output | 4 | Selected nibble of the running total |

## Verification
The assertions assume that the button and switch inputs do not change on a rising clock edge, so that a level sampled on a tick is the level that was present across that edge. They also assume `TICK_DIV` is at least 2, so two ticks are never adjacent. The bench changes every input only on the falling clock edge and shortens `TICK_DIV` to 6, which keeps runs short without changing behaviour. Because the block has no reset pin, the checker stays idle for its first clock and then starts from the power-up state.

// File: rtl/nacc_pkg.sv
package nacc_pkg;
  localparam int SUM_W = 8;
  localparam int NIB_W = 4;

  typedef logic [SUM_W-1:0] sum_t;
  typedef logic [NIB_W-1:0] nib_t;

  // Modulo-2^SUM_W add of a zero-extended nibble.
  function automatic sum_t wrap_add(input sum_t acc, input nib_t addend);
    logic [SUM_W:0] wide;
    wide = {1'b0, acc} + {{(SUM_W+1-NIB_W){1'b0}}, addend};
    return wide[SUM_W-1:0];
  endfunction

  // Pick the upper or lower half of the total for display.
  function automatic nib_t half_pick(input sum_t acc, input logic upper);
    return upper ? acc[SUM_W-1 -: NIB_W] : acc[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/nacc_tick.sv
module nacc_tick #(
  parameter int DIV = 1200000
) (
  input  logic clk,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q = '0;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (tick) cnt_q <= '0;
    else      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nacc_press.sv
module nacc_press (
  input  logic clk,
  input  logic tick,
  input  logic btn,
  output logic prev_q,
  output logic accept
);
  logic prev_r = 1'b0;

  assign prev_q = prev_r;
  assign accept = tick & btn & ~prev_r;

  // Reloaded on every tick, whether or not clear is held.
  always_ff @(posedge clk) begin
    if (tick) prev_r <= btn;
  end
endmodule

// File: rtl/nacc_sum.sv
module nacc_sum
  import nacc_pkg::*;
(
  input  logic clk,
  input  logic tick,
  input  logic clr,
  input  logic accept,
  input  nib_t din,
  output sum_t sum_q
);
  sum_t acc_r = '0;

  assign sum_q = acc_r;

  always_ff @(posedge clk) begin
    if (tick) begin
      if (clr)         acc_r <= '0;
      else if (accept) acc_r <= wrap_add(acc_r, din);
    end
  end
endmodule

// File: rtl/nacc_disp.sv
module nacc_disp
  import nacc_pkg::*;
(
  input  sum_t sum_q,
  input  logic upper,
  output nib_t led
);
  assign led = half_pick(sum_q, upper);
endmodule

// File: rtl/nibble_accum.sv
module nibble_accum
  import nacc_pkg::*;
#(
  parameter int TICK_DIV = 1200000
) (
  input  logic             clk,
  input  logic [NIB_W-1:0] din,
  input  logic             btn_clr,
  input  logic             btn_add,
  input  logic             show_hi,
  output logic [NIB_W-1:0] led
);
  logic tick;
  logic add_prev;
  logic add_accept;
  sum_t total;

  nacc_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .tick (tick)
  );

  nacc_press u_press (
    .clk    (clk),
    .tick   (tick),
    .btn    (btn_add),
    .prev_q (add_prev),
    .accept (add_accept)
  );

  nacc_sum u_sum (
    .clk    (clk),
    .tick   (tick),
    .clr    (btn_clr),
    .accept (add_accept),
    .din    (din),
    .sum_q  (total)
  );

  nacc_disp u_disp (
    .sum_q (total),
    .upper (show_hi),
    .led   (led)
  );
endmodule

// File: rtl/nacc_chk.sv
module nacc_chk
  import nacc_pkg::*;
(
  input logic clk,
  input logic tick,
  input logic add_prev,
  input logic add_accept,
  input sum_t total,
  input nib_t din,
  input logic btn_clr,
  input logic btn_add,
  input logic show_hi,
  input nib_t led
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R2: the total holds still between ticks
  a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (!armed)
    !tick |=> $stable(total));

  // R2: ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!armed)
    tick |=> !tick);

  // R1, R5: an accepted press without clear adds modulo 256
  a_r1_add_result: assert property (@(posedge clk) disable iff (!armed)
    (add_accept && !btn_clr) |=> total == sum_t'($past(total) + $past(din)));

  // R8: clear on a tick empties the total
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!armed)
    (tick && btn_clr) |=> total == '0);

  // R4, R9: the previous sample follows the button on every tick
  a_r4_prev_tracks: assert property (@(posedge clk) disable iff (!armed)
    tick |=> add_prev == $past(btn_add));

  // R3: an accepted press is never followed by another while the button stays held
  a_r3_single_add: assert property (@(posedge clk) disable iff (!armed)
    add_accept |=> add_prev);

  // R6: with the total and the select unchanged, the LEDs do not move
  a_r6_led_steady: assert property (@(posedge clk) disable iff (!armed)
    ($stable(total) && $stable(show_hi)) |-> $stable(led));
endmodule

bind nibble_accum nacc_chk u_chk (
  .clk        (clk),
  .tick       (tick),
  .add_prev   (add_prev),
  .add_accept (add_accept),
  .total      (total),
  .din        (din),
  .btn_clr    (btn_clr),
  .btn_add    (btn_add),
  .show_hi    (show_hi),
  .led        (led)
);

// File: tb/nibble_accum_tb.sv
module nibble_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic [3:0] din = 4'd0;
  logic       btn_clr = 1'b0;
  logic       btn_add = 1'b0;
  logic       show_hi = 1'b0;
  logic [3:0] led;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_sum = 0;
  int m_prev = 0;

  nibble_accum #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .din(din), .btn_clr(btn_clr), .btn_add(btn_add),
    .show_hi(show_hi), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (m_cnt == DIV - 1) begin
      if (btn_clr) m_sum = 0;
      else if (btn_add && m_prev == 0) m_sum = (m_sum + int'(din)) % 256;
      m_prev = btn_add ? 1 : 0;
      m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  // R6: cycle-by-cycle LED compare against the model
  always @(negedge clk) begin
    if (!done) begin
      int exp_led;
      exp_led = show_hi ? (m_sum / 16) : (m_sum % 16);
      checks++;
      if (int'(led) != exp_led) begin
        failures++;
        $display("FAIL R6 per-cycle led=%0d expected=%0d", led, exp_led);
      end
    end
  end

  task automatic check_total(input int exp_v, input string tag);
    int got;
    show_hi = 1'b0; #1;
    got = int'(led);
    show_hi = 1'b1; #1;
    got = got + 16 * int'(led);
    show_hi = 1'b0; #1;
    checks++;
    if (got != exp_v) begin
      failures++;
      $display("FAIL %s total=%0d expected=%0d", tag, got, exp_v);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic press(input int v);
    din = 4'(v);
    btn_add = 1'b1;
    ticks(2);
    btn_add = 1'b0;
    ticks(2);
  endtask

  task automatic align();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check_total(0, "R7 power-up");

    // R2: first tick acted on at edge DIV
    din = 4'd3; btn_add = 1'b1;
    repeat (DIV - 2) @(negedge clk);
    check_total(0, "R2 before first tick");
    @(negedge clk);
    check_total(3, "R2 first tick");
    btn_add = 1'b0; ticks(2);

    // R3: long hold adds once
    din = 4'd5; btn_add = 1'b1; ticks(8); btn_add = 1'b0; ticks(2);
    check_total(8, "R3 held press");

    // R4: rise needed after release
    press(2);
    check_total(10, "R4 second press");

    // R2: short pulse between ticks is missed
    align();
    din = 4'd7; btn_add = 1'b1;
    repeat (2) @(negedge clk);
    btn_add = 1'b0;
    ticks(2);
    check_total(10, "R2 short pulse");

    // R8: clear
    btn_clr = 1'b1; ticks(1); btn_clr = 1'b0; ticks(1);
    check_total(0, "R8 clear");

    // R1: twenty ones
    for (int i = 0; i < 20; i++) press(1);
    check_total(20, "R1 twenty ones");

    btn_clr = 1'b1; ticks(1); btn_clr = 1'b0; ticks(1);
    for (int i = 1; i <= 6; i++) press(i);
    check_total(21, "R1 one through six");

    // R5: thirteen fifteens then wrap
    btn_clr = 1'b1; ticks(1); btn_clr = 1'b0; ticks(1);
    for (int i = 0; i < 13; i++) press(15);
    check_total(195, "R5 thirteen fifteens");
    for (int i = 0; i < 5; i++) press(15);
    check_total(14, "R5 wrap");

    // R6: immediate select response
    @(negedge clk);
    show_hi = 1'b1; #1;
    checks++;
    if (led != 4'd0) begin
      failures++;
      $display("FAIL R6 immediate high led=%0d expected=0", led);
    end
    show_hi = 1'b0; #1;
    checks++;
    if (led != 4'd14) begin
      failures++;
      $display("FAIL R6 immediate low led=%0d expected=14", led);
    end

    // R8: clear and a fresh add on the same tick
    align();
    din = 4'd9; btn_add = 1'b1; btn_clr = 1'b1;
    ticks(1);
    btn_clr = 1'b0;
    // R9: add still held as clear releases
    ticks(3);
    check_total(0, "R8 clear beats add");
    btn_add = 1'b0; ticks(2);
    check_total(0, "R9 held add through clear");

    btn_clr = 1'b1; btn_add = 1'b1; din = 4'd4; ticks(2);
    btn_clr = 1'b0; ticks(2); btn_add = 1'b0; ticks(1);
    check_total(0, "R9 add held over clear release");
    press(4);
    check_total(4, "R9 next press counts");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule